// File: doc/BRIEF.md
# ADC Result Buffer with Interrupt Grouping

This block receives normal-mode conversion results from an A/D sequencer and places them in a small array of result registers. Every register keeps two flags. The stored flag shows that the register holds a result that has not been read yet. The overrun flag shows that an unread result was overwritten. A read strobe for each register tells the block that software has taken that register's value.

Where each result goes depends on the conversion mode and on a 2-bit interrupt-interval field. In fixed-channel repeat mode a write pointer steps through a group of 1, 4 or all registers. It returns to register 0 at the end of the group, and at that point the conversion-complete interrupt gives a one-cycle pulse. In every other mode each result lands in register 0 and the interrupt pulses on every result.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, all result registers read 0, all stored and overrun flags are 0, and the interrupt is 0.
- R2: When the repeat-mode input is 0, every result is written to register 0 and the interrupt pulses for every result.
- R3: In repeat mode with interval code 2'b00, every result is written to register 0 and the interrupt pulses for every result.
- R4: In repeat mode with interval code 2'b01, results go to registers 0, 1, 2, 3 and then back to 0. The interrupt pulses only for the write to register 3.
- R5: In repeat mode with interval code 2'b10 or 2'b11, results go to registers 0 through 7 in order and then back to 0. The interrupt pulses only for the write to register 7.
- R6: A register's stored flag sets when that register is written. It clears when that register's read strobe is high and no write hits the register in the same cycle.
- R7: A register's overrun flag sets when a write hits the register while its stored flag is 1 and its read strobe is 0. A read of the register clears the overrun flag.
- R8: If a register is written and read in the same cycle, its stored flag ends at 1 and its overrun flag ends at 0.
- R9: The written data, the updated flags and the interrupt all appear on the clock edge that takes the write. The interrupt is high for exactly that one cycle unless the next write also ends a group.
- R10: If the pointer lies outside the current group, the next write goes to register 0. This happens after the interval code shrinks the group, or after leaving repeat mode, which holds the pointer at 0.
- R11: A read strobe on one register does not change the contents or flags of any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Result write strobe |
| wr_data | input | DATA_W | Conversion result to store |
| fix_rpt | input | 1 | 1 = fixed-channel repeat mode |
| ival | input | 2 | Interrupt interval: 00 every result, 01 every 4, 1x every NUM_REGS |
| rd_strb | input | NUM_REGS | Read strobe per register |
| res_data | output | NUM_REGS*DATA_W | All register contents; register i sits in bits [i*DATA_W +: DATA_W] |
| res_stored | output | NUM_REGS | Stored flag per register |
| res_ovr | output | NUM_REGS | Overrun flag per register |
| irq | output | 1 | Conversion-complete interrupt pulse |

## Verification
The hardest case to reach is a pointer left partway through an eight-entry group when the interval code then switches to a four-entry group. The port-level sequence must first advance the pointer past register 3 and only then change the code. The stimulus table walks a long ordered series of writes through all interval codes, so this case is reached by plain writes. The same series also covers a repeat-mode exit in the middle of a group. Same-cycle read and write of one register is driven as a separate directed case.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

    typedef enum logic [1:0] {
        IVAL_EACH  = 2'b00,
        IVAL_FOUR  = 2'b01,
        IVAL_ALL   = 2'b10,
        IVAL_ALL_B = 2'b11
    } ival_e;

    // Group length for a given interval code; four is capped at the array size.
    function automatic int unsigned group_len(input logic [1:0] code, input int unsigned nregs);
        case (code)
            IVAL_EACH: group_len = 1;
            IVAL_FOUR: group_len = (nregs < 4) ? nregs : 4;
            default:   group_len = nregs;
        endcase
    endfunction

endpackage

// File: rtl/adc_buf_ptr.sv
module adc_buf_ptr
    import adc_buf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             fix_rpt,
    input  logic [1:0]       ival,
    output logic [PTR_W-1:0] tgt_idx,
    output logic             irq
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             irq;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    logic [PTR_W:0] grp_len;
    logic [PTR_W:0] nxt_pos;
    logic [PTR_W-1:0] tgt;
    logic           wrap;

    always_comb begin
        grp_len = fix_rpt ? (PTR_W+1)'(group_len(ival, NUM_REGS)) : (PTR_W+1)'(1);
        tgt     = (fix_rpt && ({1'b0, st_q.ptr} < grp_len)) ? st_q.ptr : '0;
        nxt_pos = {1'b0, tgt} + (PTR_W+1)'(1);
        wrap    = (nxt_pos == grp_len);

        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_en) begin
            st_d.ptr = wrap ? '0 : nxt_pos[PTR_W-1:0];
            st_d.irq = wrap;
        end else if (!fix_rpt) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_idx = tgt;
    assign irq     = st_q.irq;

    assert_irq_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wr_en));
    assert_plain_mode_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fix_rpt) |=> irq);
    assert_each_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fix_rpt && ival == 2'b00) |=> irq);
    assert_plain_mode_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fix_rpt) |-> (tgt_idx == '0));

endmodule

// File: rtl/adc_buf_slot.sv
module adc_buf_slot #(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data,
    output logic              stored,
    output logic              ovr
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              stored;
        logic              ovr;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.stored = 1'b0;
            st_d.ovr    = 1'b0;
        end
        if (wr) begin
            st_d.data   = wdata;
            st_d.stored = 1'b1;
            if (st_q.stored && !rd) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data   = st_q.data;
    assign stored = st_q.stored;
    assign ovr    = st_q.ovr;

    assert_ovr_has_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> stored);
    assert_write_sets_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> stored);
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> (!stored && !ovr));
    assert_overwrite_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && stored) |=> ovr);
    assert_same_cycle_rw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rd) |=> (stored && !ovr));
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !rd) |=> ($stable(data) && $stable(stored) && $stable(ovr)));

endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       fix_rpt,
    input  logic [1:0]                 ival,
    input  logic [NUM_REGS-1:0]        rd_strb,
    output logic [NUM_REGS*DATA_W-1:0] res_data,
    output logic [NUM_REGS-1:0]        res_stored,
    output logic [NUM_REGS-1:0]        res_ovr,
    output logic                       irq
);

    localparam int unsigned PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [PTR_W-1:0]    tgt_idx;
    logic [NUM_REGS-1:0] slot_wr;

    adc_buf_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .fix_rpt (fix_rpt),
        .ival    (ival),
        .tgt_idx (tgt_idx),
        .irq     (irq)
    );

    always_comb begin
        slot_wr = '0;
        if (wr_en) slot_wr[tgt_idx] = 1'b1;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        adc_buf_slot #(.DATA_W(DATA_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (slot_wr[i]),
            .rd     (rd_strb[i]),
            .wdata  (wr_data),
            .data   (res_data[i*DATA_W +: DATA_W]),
            .stored (res_stored[i]),
            .ovr    (res_ovr[i])
        );
    end

    assert_one_slot_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_wr) && (wr_en == (slot_wr != '0)));
    assert_flags_consistent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ovr & ~res_stored) == '0);

endmodule

// File: tb/adc_result_buffer_test.sv
module adc_result_buffer_test;

    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned DATA_W   = 10;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 25;

    // Vector: {fix_rpt, ival[1:0], expected index[2:0], expected irq}
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 3'd0, 1'b1},  // R2
        {1'b0, 2'b00, 3'd0, 1'b1},  // R2
        {1'b1, 2'b00, 3'd0, 1'b1},  // R3
        {1'b1, 2'b00, 3'd0, 1'b1},  // R3
        {1'b1, 2'b01, 3'd0, 1'b0},  // R4
        {1'b1, 2'b01, 3'd1, 1'b0},
        {1'b1, 2'b01, 3'd2, 1'b0},
        {1'b1, 2'b01, 3'd3, 1'b1},
        {1'b1, 2'b01, 3'd0, 1'b0},
        {1'b1, 2'b10, 3'd1, 1'b0},  // R5
        {1'b1, 2'b10, 3'd2, 1'b0},
        {1'b1, 2'b10, 3'd3, 1'b0},
        {1'b1, 2'b10, 3'd4, 1'b0},
        {1'b1, 2'b10, 3'd5, 1'b0},
        {1'b1, 2'b01, 3'd0, 1'b0},  // R10 pointer at 6 outside group of 4
        {1'b1, 2'b11, 3'd1, 1'b0},  // R5 code 11
        {1'b1, 2'b11, 3'd2, 1'b0},
        {1'b1, 2'b11, 3'd3, 1'b0},
        {1'b1, 2'b11, 3'd4, 1'b0},
        {1'b1, 2'b11, 3'd5, 1'b0},
        {1'b1, 2'b11, 3'd6, 1'b0},
        {1'b1, 2'b11, 3'd7, 1'b1},
        {1'b1, 2'b11, 3'd0, 1'b0},
        {1'b0, 2'b00, 3'd0, 1'b1},  // R10 leaving repeat mode
        {1'b1, 2'b01, 3'd0, 1'b0}   // R10 restart at 0
    };

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       wr_en = 1'b0;
    logic [DATA_W-1:0]          wr_data = '0;
    logic                       fix_rpt = 1'b0;
    logic [1:0]                 ival = 2'b00;
    logic [NUM_REGS-1:0]        rd_strb = '0;
    logic [NUM_REGS*DATA_W-1:0] res_data;
    logic [NUM_REGS-1:0]        res_stored;
    logic [NUM_REGS-1:0]        res_ovr;
    logic                       irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    adc_result_buffer #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fix_rpt(fix_rpt), .ival(ival), .rd_strb(rd_strb),
        .res_data(res_data), .res_stored(res_stored), .res_ovr(res_ovr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int reg_val(input int idx);
        return int'(res_data[idx*DATA_W +: DATA_W]);
    endfunction

    // Drive inputs at a falling edge, let one rising edge take them, return at the next falling edge.
    task automatic step(input logic w, input logic [DATA_W-1:0] d, input logic [NUM_REGS-1:0] rd);
        wr_en = w; wr_data = d; rd_strb = rd;
        @(negedge clk);
        wr_en = 1'b0; rd_strb = '0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "data", int'(res_data != '0), 0);
        check("R1", "stored", int'(res_stored), 0);
        check("R1", "ovr", int'(res_ovr), 0);
        check("R1", "irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [6:0] e;
            e = VEC[v];
            fix_rpt = e[6];
            ival    = e[5:4];
            step(1'b1, DATA_W'(100 + v), '0);
            check("R4", $sformatf("vec %0d data in reg %0d", v, e[3:1]), reg_val(int'(e[3:1])), 100 + v);
            check("R5", $sformatf("vec %0d irq", v), int'(irq), int'(e[0]));
        end

        // R9 irq drops when no write follows
        step(1'b0, '0, '0);
        check("R9", "irq low after idle", int'(irq), 0);

        // Clear everything by reading all registers
        step(1'b0, '0, '1);
        check("R6", "read clears stored", int'(res_stored), 0);
        check("R7", "read clears ovr", int'(res_ovr), 0);

        fix_rpt = 1'b0;
        step(1'b1, 10'd500, '0);
        check("R6", "stored after write", int'(res_stored), 1);
        check("R7", "no ovr on first write", int'(res_ovr), 0);
        check("R9", "data same edge", reg_val(0), 500);
        step(1'b1, 10'd501, '0);
        check("R7", "ovr on unread overwrite", int'(res_ovr), 1);
        check("R6", "stored still set", int'(res_stored), 1);

        // R11 read of another register leaves reg 0 alone
        step(1'b0, '0, 8'b0000_0010);
        check("R11", "stored kept", int'(res_stored[0]), 1);
        check("R11", "ovr kept", int'(res_ovr[0]), 1);
        check("R11", "data kept", reg_val(0), 501);

        step(1'b0, '0, 8'b0000_0001);
        check("R6", "read clears reg0 stored", int'(res_stored[0]), 0);
        check("R7", "read clears reg0 ovr", int'(res_ovr[0]), 0);

        // R8 same-cycle read and write with stored flag set
        step(1'b1, 10'd600, '0);
        step(1'b1, 10'd601, 8'b0000_0001);
        check("R8", "stored after rw", int'(res_stored[0]), 1);
        check("R8", "ovr after rw", int'(res_ovr[0]), 0);
        check("R8", "data after rw", reg_val(0), 601);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule